// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory (Slave)

This block is a slave on a two-wire serial bus that holds 2048 bytes. A master frames every transfer with a START and a STOP condition. It addresses the device with a select byte that also carries the three high word-address bits. It then writes bytes into a 16-byte page or reads bytes back one after another. The data line is open-drain: the block only pulls it low through an output-enable and otherwise leaves the line to the external pull-up.

Both bus lines are sampled with the system clock through a synchronizer. The block finds clock edges and START/STOP conditions in those samples. A random read is a write transfer that carries only the address, followed by a repeated START and a read select byte. After a STOP that ends a transfer carrying data, the block starts a write cycle of a set number of system clocks. During that cycle it ignores the bus entirely, so a master polls with select bytes until one is acknowledged.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the data-line drive is off (`sda_oe` = 0) and the block waits for a START without responding.
- R2: A START is the data line falling while the clock line is high, and a STOP is the data line rising while the clock line is high. The block changes `sda_oe` only while the clock line is low.
- R3: A select byte whose bits 7:4 are 1010 is acknowledged by pulling the data line low during the ninth clock. Any other select byte gets no acknowledge, and the block then ignores the bus until the next START.
- R4: Select-byte bits 3:1 give word-address bits 10:8 and bit 0 is the direction (0 = write, 1 = read). In a write transfer the next byte gives word-address bits 7:0. Every byte travels most significant bit first.
- R5: Each data byte of a write transfer is acknowledged and stored at the current word address.
- R6: Within a write transfer the address advances only in bits 3:0, which wrap from 15 to 0 while bits 10:4 stay fixed. A transfer of more than 16 bytes therefore overwrites the earliest bytes of the same page.
- R7: A write transfer that carries only the address, followed by a repeated START and a read select byte, returns the byte at that address.
- R8: A read returns bytes from successive addresses for as long as the master acknowledges each one, and the address wraps from 2047 to 0. A master NACK ends the read and releases the line.
- R9: A STOP that follows at least one data byte starts a write cycle of WR_CYCLES clocks. During that cycle the block ignores all bus activity and acknowledges nothing. Afterwards a valid select byte is acknowledged again.
- R10: A STOP at any point, even in the middle of a byte, returns the block to standby. If no data byte was sent, no write cycle starts and the address that was loaded becomes the current address.
- R11: The block never drives the data line high. A 1 bit, on data or on acknowledge, is sent by releasing the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus lines and run the write-cycle timer |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it to the pull-up |

## Verification
The assertions assume that the bus clock stays level for several system clocks on each side of every edge. They also assume that the master changes the data line during a transfer only while the clock line is low, except for the deliberate START and STOP edges. The bench holds each clock phase for eight system clocks and changes data four clocks after a falling edge, which leaves room for the synchronizer delay. Because the bus is a wired-AND of the master and the block, a START or STOP can never arise while the block is holding the line low. The assertions on drive timing rely on this.

// File: rtl/twi_ee_pkg.sv
package twi_ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } twi_state_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WADDR,
    PH_DATA
  } twi_phase_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/twi_line_events.sv
module twi_line_events #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_chain;
  logic [SYNC_STAGES-1:0] sda_chain;
  logic                   scl_p;
  logic                   sda_p;

  // Both lines share one chain depth so their relative timing is kept.
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_i;
          sda_chain <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
          sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_chain[LAST];
      sda_p <= sda_chain[LAST];
    end
  end

  assign scl_lvl  = scl_chain[LAST];
  assign sda_lvl  = sda_chain[LAST];
  assign scl_rise = scl_lvl & ~scl_p;
  assign scl_fall = ~scl_lvl & scl_p;
  assign start_ev = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_p & ~sda_p & sda_lvl;

endmodule

// File: rtl/twi_wr_timer.sv
module twi_wr_timer #(
  parameter int unsigned CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy
);

  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (go && !busy) begin
      cnt_q <= LOAD;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);

  AST_WR_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy); // R9

endmodule

// File: rtl/twi_ee_store.sv
module twi_ee_store #(
  parameter int unsigned ADDR_BITS = 11,
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ADDR_BITS-1:0] waddr,
  input  logic [DATA_BITS-1:0] wdata,
  input  logic [ADDR_BITS-1:0] raddr,
  output logic [DATA_BITS-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_BITS;

  logic [DATA_BITS-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import twi_ee_pkg::*;
#(
  parameter int unsigned ADDR_BITS   = 11,
  parameter int unsigned PAGE_BITS   = 4,
  parameter int unsigned WR_CYCLES   = 5000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam int unsigned BLK_BITS = ADDR_BITS - BYTE_BITS;
  localparam int unsigned HI_BITS  = ADDR_BITS - PAGE_BITS;

  // Next address inside a page write: only the page offset moves.
  function automatic logic [ADDR_BITS-1:0] page_step(input logic [ADDR_BITS-1:0] a);
    logic [PAGE_BITS-1:0] off;
    off = PAGE_BITS'(a[PAGE_BITS-1:0] + 1'b1);
    return {a[ADDR_BITS-1:PAGE_BITS], off};
  endfunction

  // Next address of a read: the whole address moves and wraps at the top.
  function automatic logic [ADDR_BITS-1:0] seq_step(input logic [ADDR_BITS-1:0] a);
    return ADDR_BITS'(a + 1'b1);
  endfunction

  // Line events
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

  twi_line_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  // State
  twi_state_e               state_q;
  twi_phase_e               phase_q;
  logic [BYTE_BITS-1:0]     shreg_q;
  logic [3:0]               bitcnt_q;
  logic [ADDR_BITS-1:0]     addr_q;
  logic                     sda_oe_q;
  logic                     rd_mode_q;
  logic                     mack_q;
  logic                     wr_pend_q;

  // Named internal events
  logic                 busy;
  logic                 byte_done;
  logic                 dev_hit;
  logic                 wr_en;
  logic                 wcyc_go;
  logic [BYTE_BITS-1:0] rdata;

  assign byte_done = (state_q == ST_RX) && scl_fall && (bitcnt_q == 4'd8);
  assign dev_hit   = (shreg_q[7:4] == DEV_CODE);
  assign wr_en     = byte_done && (phase_q == PH_DATA) && !busy;
  assign wcyc_go   = stop_ev && wr_pend_q && !busy;

  twi_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (wcyc_go),
    .busy  (busy)
  );

  twi_ee_store #(.ADDR_BITS(ADDR_BITS), .DATA_BITS(BYTE_BITS)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (addr_q),
    .wdata (shreg_q),
    .raddr (addr_q),
    .rdata (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_DEV;
      shreg_q   <= '0;
      bitcnt_q  <= '0;
      addr_q    <= '0;
      sda_oe_q  <= 1'b0;
      rd_mode_q <= 1'b0;
      mack_q    <= 1'b0;
      wr_pend_q <= 1'b0;
    end else if (busy) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else if (start_ev) begin
      state_q  <= ST_RX;
      phase_q  <= PH_DEV;
      bitcnt_q <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_ev) begin
      state_q   <= ST_IDLE;
      sda_oe_q  <= 1'b0;
      wr_pend_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && (bitcnt_q < 4'd8)) begin
            shreg_q  <= {shreg_q[BYTE_BITS-2:0], sda_lvl};
            bitcnt_q <= 4'(bitcnt_q + 1'b1);
          end else if (byte_done) begin
            unique case (phase_q)
              PH_DEV: begin
                if (dev_hit) begin
                  addr_q[ADDR_BITS-1:BYTE_BITS] <= shreg_q[BLK_BITS:1];
                  rd_mode_q <= shreg_q[0];
                  phase_q   <= PH_WADDR;
                  sda_oe_q  <= 1'b1;
                  state_q   <= ST_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              PH_WADDR: begin
                addr_q[BYTE_BITS-1:0] <= shreg_q;
                phase_q  <= PH_DATA;
                sda_oe_q <= 1'b1;
                state_q  <= ST_ACK;
              end
              default: begin
                addr_q    <= page_step(addr_q);
                wr_pend_q <= 1'b1;
                sda_oe_q  <= 1'b1;
                state_q   <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt_q <= '0;
            if (rd_mode_q) begin
              shreg_q  <= rdata;
              sda_oe_q <= ~rdata[BYTE_BITS-1];
              addr_q   <= seq_step(addr_q);
              state_q  <= ST_TX;
            end else begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt_q <= 4'(bitcnt_q + 1'b1);
          end else if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_MACK;
            end else begin
              shreg_q  <= {shreg_q[BYTE_BITS-2:0], 1'b0};
              sda_oe_q <= ~shreg_q[BYTE_BITS-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_lvl;
          end else if (scl_fall) begin
            bitcnt_q <= '0;
            if (mack_q) begin
              shreg_q  <= rdata;
              sda_oe_q <= ~rdata[BYTE_BITS-1];
              addr_q   <= seq_step(addr_q);
              state_q  <= ST_TX;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: begin
          sda_oe_q <= 1'b0;
        end
      endcase
    end
  end

  assign sda_oe = sda_oe_q;

  AST_OE_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_q) |-> !scl_lvl); // R2

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe_q); // R9

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (addr_q[ADDR_BITS-1:PAGE_BITS] == $past(addr_q[ADDR_BITS-1:PAGE_BITS]))); // R6

  AST_STOP_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !busy) |=> ((state_q == ST_IDLE) && !sda_oe_q)); // R10

  AST_NO_ACK_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (phase_q == PH_DEV) && !dev_hit && !busy) |=> !sda_oe_q); // R3

  AST_DRIVE_STATES: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_q |-> ((state_q == ST_ACK) || (state_q == ST_TX))); // R11

  AST_HI_BITS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (HI_BITS + PAGE_BITS == ADDR_BITS) |-> (wr_en |-> !rd_mode_q)); // R5

endmodule

// File: tb/tb_twi_eeprom_slave.sv
`timescale 1ns/1ps
module tb_twi_eeprom_slave;

  localparam int WR = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  twi_eeprom_slave #(.WR_CYCLES(WR)) dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl),
    .sda_i  (sda_bus),
    .sda_oe (sda_oe)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int glitches = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0;
  logic [7:0] model [2048];

  // R2 monitor: drive may only move while the bus clock is low.
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl) glitches++;
    prev_oe = sda_oe;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(2); scl = 1'b1; tick(4);
    sda_m = 1'b0; tick(4); scl = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4); scl = 1'b1; tick(4);
    sda_m = 1'b1; tick(4);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(4); scl = 1'b1; tick(8); scl = 1'b0; tick(4);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(4); scl = 1'b1; tick(4);
    b = sda_bus; tick(4); scl = 1'b0; tick(4);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  function automatic logic [7:0] sel(input logic [10:0] a, input logic rd);
    return {4'b1010, a[10:8], rd};
  endfunction

  task automatic wait_ready(output int polls);
    logic ack;
    polls = 0;
    ack = 1'b0;
    while (!ack && polls < 40) begin
      bus_start();
      put_byte(8'hA0, ack);
      bus_stop();
      polls++;
    end
  endtask

  // Page write: data value for byte i is base + 7*i.
  task automatic page_write(input logic [10:0] a, input int n, input logic [7:0] base);
    logic ack;
    int polls;
    logic [10:0] p;
    bus_start();
    put_byte(sel(a, 1'b0), ack); check("R3 select ack", ack, 1);
    put_byte(a[7:0], ack);       check("R4 address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'(base + 7 * i);
      put_byte(d, ack); check("R5 data ack", ack, 1);
      p = {a[10:4], 4'(a[3:0] + i)};
      model[p] = d;
    end
    bus_stop();
    wait_ready(polls);
    check("R9 ready after cycle", int'(polls < 40), 1);
  endtask

  task automatic random_read(input logic [10:0] a, input int n, input string req);
    logic ack;
    logic [7:0] v;
    bus_start();
    put_byte(sel(a, 1'b0), ack); check("R7 dummy select ack", ack, 1);
    put_byte(a[7:0], ack);       check("R7 dummy address ack", ack, 1);
    bus_start();
    put_byte(sel(a, 1'b1), ack); check("R7 read select ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, v);
      check(req, v, model[11'(a + i)]);
    end
    bus_stop();
  endtask

  task automatic t_reset();
    tick(20);
    check("R1 drive off after reset", sda_oe, 0);
    scl = 1'b0; tick(10); scl = 1'b1; tick(10);
    check("R1 no response without START", sda_oe, 0);
  endtask

  task automatic t_byte();
    page_write(11'h123, 1, 8'h96);
    random_read(11'h123, 1, "R5 byte read back");
    page_write(11'h200, 1, 8'hFF);
    page_write(11'h201, 1, 8'h00);
    random_read(11'h200, 2, "R11 all-ones and all-zeros bytes");
  endtask

  task automatic t_foreign();
    logic ack;
    bus_start();
    put_byte(8'hB0, ack); check("R3 foreign select nack", ack, 0);
    put_byte(8'hA0, ack); check("R3 ignored until START", ack, 0);
    bus_stop();
    bus_start();
    put_byte(8'hA0, ack); check("R3 valid select acked again", ack, 1);
    bus_stop();
  endtask

  task automatic t_busy();
    logic ack;
    int polls;
    page_write(11'h050, 1, 8'h3C);
    // a second write whose cycle is probed right away
    bus_start();
    put_byte(sel(11'h051, 1'b0), ack);
    put_byte(8'h51, ack);
    put_byte(8'hE1, ack);
    model[11'h051] = 8'hE1;
    bus_stop();
    bus_start();
    put_byte(8'hA0, ack); check("R9 nack while busy", ack, 0);
    bus_stop();
    wait_ready(polls);
    check("R9 acked after cycle ends", int'(polls >= 1 && polls < 40), 1);
    random_read(11'h050, 2, "R9 data after cycle");
  endtask

  task automatic t_page();
    page_write(11'h130, 1, 8'h77);
    page_write(11'h11F, 1, 8'h66);
    page_write(11'h12E, 18, 8'h10);
    random_read(11'h11F, 18, "R6 page wrap and neighbours");
  endtask

  task automatic t_wrap();
    page_write(11'h7FF, 1, 8'h5A);
    page_write(11'h000, 1, 8'hC3);
    random_read(11'h7FF, 2, "R8 address wraps 2047 to 0");
    random_read(11'h120, 16, "R8 sequential read");
    check("R8 line released after NACK", sda_oe, 0);
  endtask

  task automatic t_abort();
    logic ack;
    logic [7:0] v;
    page_write(11'h345, 1, 8'hA5);
    bus_start();
    put_byte(sel(11'h345, 1'b0), ack);
    put_byte(8'h45, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    check("R10 standby after STOP mid-byte", sda_oe, 0);
    bus_start();
    put_byte(sel(11'h345, 1'b1), ack);
    check("R10 no write cycle without data", ack, 1);
    get_byte(1'b0, v);
    check("R10 current address kept", v, 8'hA5);
    bus_stop();
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    t_reset();
    t_byte();
    t_foreign();
    t_busy();
    t_page();
    t_wrap();
    t_abort();
    check("R2 drive changes only with clock low", glitches, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule